// File: doc/BRIEF.md
# USB Device State Command Register

This block holds the function-level state of a USB device and applies it to incoming tokens. Firmware reaches it through a byte-wide command port: a command byte chooses a register, and the data byte after it writes that register. Three registers exist. The address register holds a 7-bit function address and an enable flag. The configuration register holds a configured flag. The mode register holds an always-clock bit and a bit that qualifies interrupts on NAKed control IN transactions.

An address written by firmware does not take effect straight away. It is held pending until the status stage of the running control transfer completes, and only then becomes the address the block answers to. A bus reset puts the function back into its default state: address 0, enabled, not configured. From this state the block decides whether each token should be answered. It also drives an active-low connect LED and a clock-request line, and it raises the interrupt for control IN transactions.

Top module: `usbd_state_cmd`

## Requirements
- R1: A command byte 0xD0 followed by a data byte loads data bits 6:0 into the pending address. Data bit 7 becomes the device-enable flag (`dev_en`) on the next cycle.
- R2: A pending address becomes the active address (`dev_addr`) in the cycle after a `status_done` pulse. A `status_done` pulse with no address pending changes nothing. An address written in the same cycle as `status_done` stays pending and is not made active.
- R3: A `bus_reset` pulse sets the active address to 0, `dev_en` to 1 and the configured flag to 0. It also drops any pending address and returns the command decoder to idle. It leaves the mode bits unchanged, and it takes priority over a write in the same cycle.
- R4: A command byte 0xD8 followed by a data byte sets the configured flag from data bit 0. `cfg_rd` shows the flag in bit 0, with bits 7:1 always 0.
- R5: A command byte 0xF3 followed by a data byte sets the always-clock bit from data bit 0 and the NAK-interrupt bit from data bit 1. `mode_rd` shows these in bits 1:0, with bits 7:2 always 0.
- R6: `tok_accept` is 1 only when `tok_valid` is 1, `dev_en` is 1 and `tok_addr` equals the active address.
- R7: Endpoint 0 is the control endpoint and is answered whether or not the device is configured. Any other endpoint is answered only when the configured flag is 1 and its bit in `ep_en` is 1.
- R8: `led_n` is 0 exactly when the configured flag is 1 and `suspended` is 0.
- R9: `clk_req` is 1 when the always-clock bit is 1 or `suspended` is 0, and 0 otherwise.
- R10: `ctl_in_irq` is 1 for an accepted endpoint-0 IN token (`tok_in` = 1) when `txn_ok` is 1. It is also 1 when `txn_nak` is 1 and the NAK-interrupt bit is set. Otherwise it is 0.
- R11: A data byte that does not follow a recognised command byte is discarded. An unrecognised command byte changes no state and returns the decoder to idle. Each recognised command byte accepts exactly one data byte.
- R12: `rst` sets the active address to 0, `dev_en` to 1, and the configured flag and both mode bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command port byte strobe |
| cmd_is_code | input | 1 | 1: byte is a command code, 0: byte is data |
| cmd_byte | input | 8 | Command port byte |
| bus_reset | input | 1 | USB bus reset pulse |
| status_done | input | 1 | Control transfer status stage complete pulse |
| suspended | input | 1 | Device is in suspend |
| tok_valid | input | 1 | Token present |
| tok_addr | input | 7 | Token function address |
| tok_ep | input | EP_W | Token endpoint number |
| tok_in | input | 1 | Token direction is IN |
| ep_en | input | 2**EP_W | Per-endpoint enable mask |
| txn_ok | input | 1 | Current transaction succeeded |
| txn_nak | input | 1 | Current transaction was NAKed |
| tok_accept | output | 1 | Token should be answered |
| ctl_in_irq | output | 1 | Control IN interrupt |
| led_n | output | 1 | Active-low connect LED |
| clk_req | output | 1 | Clock request |
| dev_addr | output | 7 | Active function address |
| dev_en | output | 1 | Device enable flag |
| cfg_rd | output | 8 | Configuration register value |
| mode_rd | output | 8 | Mode register value |

## Verification
Two kinds of event can land in the same cycle. A bus reset can coincide with a register data write, and a status-stage completion can coincide with a new address write. The bench forces both collisions directly: it writes an address while `status_done` pulses, and it asserts `bus_reset` on the very cycle a data byte for the address or configuration register arrives. It then checks the result against a behavioural model. Bus reset must win outright, and only the previously pending address may become active.

// File: rtl/usbd_state_pkg.sv
package usbd_state_pkg;

    localparam int ADDR_W = 7;

    localparam logic [7:0] CODE_SET_ADDR = 8'hD0;
    localparam logic [7:0] CODE_CONFIG   = 8'hD8;
    localparam logic [7:0] CODE_MODE     = 8'hF3;

    typedef enum logic [1:0] {
        EXP_NONE = 2'd0,
        EXP_ADDR = 2'd1,
        EXP_CONF = 2'd2,
        EXP_MODE = 2'd3
    } expect_e;

    typedef struct packed {
        logic       addr;
        logic       conf;
        logic       mode;
        logic [7:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic              configured;
        logic              always_clk;
        logic              nak_irq;
    } dev_state_t;

    function automatic expect_e decode_code(input logic [7:0] code);
        case (code)
            CODE_SET_ADDR: decode_code = EXP_ADDR;
            CODE_CONFIG:   decode_code = EXP_CONF;
            CODE_MODE:     decode_code = EXP_MODE;
            default:       decode_code = EXP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/usbd_cmd_decode.sv
module usbd_cmd_decode
    import usbd_state_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_reset,
    input  logic       cmd_valid,
    input  logic       cmd_is_code,
    input  logic [7:0] cmd_byte,
    output reg_wr_t    wr
);

    expect_e pending_q;

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            pending_q <= EXP_NONE;
        end else if (cmd_valid) begin
            if (cmd_is_code) pending_q <= decode_code(cmd_byte);
            else             pending_q <= EXP_NONE;
        end
    end

    always_comb begin
        wr      = '0;
        wr.data = cmd_byte;
        if (cmd_valid && !cmd_is_code) begin
            wr.addr = (pending_q == EXP_ADDR);
            wr.conf = (pending_q == EXP_CONF);
            wr.mode = (pending_q == EXP_MODE);
        end
    end

    // A data strobe to a register needs a decoder that was armed by a code
    AST_DATA_NEEDS_CODE: assert property (@(posedge clk) disable iff (rst)
        (wr.addr || wr.conf || wr.mode) |-> (pending_q != EXP_NONE)); // R11

    AST_DECODER_IDLE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_is_code) |=> (pending_q == EXP_NONE)); // R11

endmodule

// File: rtl/usbd_dev_regs.sv
module usbd_dev_regs
    import usbd_state_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_reset,
    input  logic       status_done,
    input  reg_wr_t    wr,
    output dev_state_t st
);

    logic [ADDR_W-1:0] pend_addr_q;
    logic              pend_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= '{en: 1'b1, addr: '0, configured: 1'b0,
                             always_clk: 1'b0, nak_irq: 1'b0};
            pend_addr_q <= '0;
            pend_vld_q  <= 1'b0;
        end else if (bus_reset) begin
            st.en         <= 1'b1;
            st.addr       <= '0;
            st.configured <= 1'b0;
            pend_vld_q    <= 1'b0;
        end else begin
            if (status_done && pend_vld_q) begin
                st.addr    <= pend_addr_q;
                pend_vld_q <= 1'b0;
            end
            if (wr.addr) begin
                pend_addr_q <= wr.data[ADDR_W-1:0];
                pend_vld_q  <= 1'b1;
                st.en       <= wr.data[7];
            end
            if (wr.conf) st.configured <= wr.data[0];
            if (wr.mode) begin
                st.always_clk <= wr.data[0];
                st.nak_irq    <= wr.data[1];
            end
        end
    end

    AST_BUSRST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (st.addr == '0 && st.en && !st.configured)); // R3

    AST_ADDR_ONLY_ON_STATUS: assert property (@(posedge clk) disable iff (rst)
        (!status_done && !bus_reset) |=> $stable(st.addr)); // R2

    AST_MODE_KEEPS_ON_BUSRST: assert property (@(posedge clk) disable iff (rst)
        (bus_reset && !wr.mode) |=> ($stable(st.always_clk) && $stable(st.nak_irq))); // R3

endmodule

// File: rtl/usbd_tok_match.sv
module usbd_tok_match
    import usbd_state_pkg::*;
#(
    parameter int EP_W = 4,
    localparam int NUM_EP = 1 << EP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  dev_state_t        st,
    input  logic              suspended,
    input  logic              tok_valid,
    input  logic [ADDR_W-1:0] tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              tok_in,
    input  logic [NUM_EP-1:0] ep_en,
    input  logic              txn_ok,
    input  logic              txn_nak,
    output logic              tok_accept,
    output logic              ctl_in_irq,
    output logic              led_n,
    output logic              clk_req
);

    logic addr_hit, is_ctrl, ep_open;

    always_comb begin
        is_ctrl    = (tok_ep == '0);
        addr_hit   = tok_valid && st.en && (tok_addr == st.addr);
        ep_open    = is_ctrl || (st.configured && ep_en[tok_ep]);
        tok_accept = addr_hit && ep_open;
        ctl_in_irq = tok_accept && is_ctrl && tok_in &&
                     (txn_ok || (txn_nak && st.nak_irq));
        led_n      = !(st.configured && !suspended);
        clk_req    = st.always_clk || !suspended;
    end

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        !st.en |-> !tok_accept); // R6

    AST_UNCONF_CTRL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (tok_accept && !st.configured) |-> (tok_ep == '0)); // R7

    AST_LED_OFF_SUSPENDED: assert property (@(posedge clk) disable iff (rst)
        suspended |-> led_n); // R8

    AST_CLK_HELD: assert property (@(posedge clk) disable iff (rst)
        st.always_clk |-> clk_req); // R9

    AST_IRQ_CTRL_IN: assert property (@(posedge clk) disable iff (rst)
        ctl_in_irq |-> (tok_in && tok_accept)); // R10

endmodule

// File: rtl/usbd_state_cmd.sv
module usbd_state_cmd
    import usbd_state_pkg::*;
#(
    parameter int EP_W = 4,
    localparam int NUM_EP = 1 << EP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_is_code,
    input  logic [7:0]        cmd_byte,
    input  logic              bus_reset,
    input  logic              status_done,
    input  logic              suspended,
    input  logic              tok_valid,
    input  logic [6:0]        tok_addr,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic              tok_in,
    input  logic [NUM_EP-1:0] ep_en,
    input  logic              txn_ok,
    input  logic              txn_nak,
    output logic              tok_accept,
    output logic              ctl_in_irq,
    output logic              led_n,
    output logic              clk_req,
    output logic [6:0]        dev_addr,
    output logic              dev_en,
    output logic [7:0]        cfg_rd,
    output logic [7:0]        mode_rd
);

    reg_wr_t    wr;
    dev_state_t st;

    usbd_cmd_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .bus_reset   (bus_reset),
        .cmd_valid   (cmd_valid),
        .cmd_is_code (cmd_is_code),
        .cmd_byte    (cmd_byte),
        .wr          (wr)
    );

    usbd_dev_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_reset   (bus_reset),
        .status_done (status_done),
        .wr          (wr),
        .st          (st)
    );

    usbd_tok_match #(.EP_W(EP_W)) u_match (
        .clk        (clk),
        .rst        (rst),
        .st         (st),
        .suspended  (suspended),
        .tok_valid  (tok_valid),
        .tok_addr   (tok_addr),
        .tok_ep     (tok_ep),
        .tok_in     (tok_in),
        .ep_en      (ep_en),
        .txn_ok     (txn_ok),
        .txn_nak    (txn_nak),
        .tok_accept (tok_accept),
        .ctl_in_irq (ctl_in_irq),
        .led_n      (led_n),
        .clk_req    (clk_req)
    );

    always_comb begin
        dev_addr = st.addr;
        dev_en   = st.en;
        cfg_rd   = {7'b0, st.configured};
        mode_rd  = {6'b0, st.nak_irq, st.always_clk};
    end

endmodule

// File: tb/usbd_state_cmd_tb_top.sv
module usbd_state_cmd_tb_top;

    localparam int EP_W   = 4;
    localparam int NUM_EP = 1 << EP_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 0, cmd_is_code = 0;
    logic [7:0] cmd_byte = '0;
    logic bus_reset = 0, status_done = 0, suspended = 0;
    logic tok_valid = 0, tok_in = 0, txn_ok = 0, txn_nak = 0;
    logic [6:0] tok_addr = '0;
    logic [EP_W-1:0] tok_ep = '0;
    logic [NUM_EP-1:0] ep_en = '0;
    logic tok_accept, ctl_in_irq, led_n, clk_req, dev_en;
    logic [6:0] dev_addr;
    logic [7:0] cfg_rd, mode_rd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    usbd_state_cmd #(.EP_W(EP_W)) dut_i (.*);

    always #5 clk = ~clk;

    // Behavioural reference state
    int m_addr = 0, m_pend = 0, m_exp = 0;
    bit m_pv = 0, m_en = 1, m_cfg = 0, m_ac = 0, m_ni = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_addr = 0; m_en = 1; m_cfg = 0; m_ac = 0; m_ni = 0; m_pv = 0; m_exp = 0;
        end else if (bus_reset) begin
            m_addr = 0; m_en = 1; m_cfg = 0; m_pv = 0; m_exp = 0;
        end else begin
            if (status_done && m_pv) begin m_addr = m_pend; m_pv = 0; end
            if (cmd_valid) begin
                if (cmd_is_code) begin
                    m_exp = (cmd_byte == 8'hD0) ? 1 : (cmd_byte == 8'hD8) ? 2 :
                            (cmd_byte == 8'hF3) ? 3 : 0;
                end else begin
                    case (m_exp)
                        1: begin m_pend = cmd_byte[6:0]; m_pv = 1; m_en = cmd_byte[7]; end
                        2: m_cfg = cmd_byte[0];
                        3: begin m_ac = cmd_byte[0]; m_ni = cmd_byte[1]; end
                        default: ;
                    endcase
                    m_exp = 0;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Compare outputs with the model after inputs have settled
    always @(negedge clk) begin
        if (!rst && !done) begin
            #2;
            begin
                bit acc, irq;
                acc = tok_valid && m_en && (tok_addr == m_addr[6:0]) &&
                      ((tok_ep == 0) || (m_cfg && ep_en[tok_ep]));
                irq = acc && (tok_ep == 0) && tok_in && (txn_ok || (txn_nak && m_ni));
                chk("R1/R2 dev_addr", dev_addr, m_addr);
                chk("R1/R3 dev_en", dev_en, m_en);
                chk("R4 cfg_rd", cfg_rd, {7'b0, m_cfg});
                chk("R5 mode_rd", mode_rd, {6'b0, m_ni, m_ac});
                chk("R6/R7 tok_accept", tok_accept, acc);
                chk("R8 led_n", led_n, !(m_cfg && !suspended));
                chk("R9 clk_req", clk_req, m_ac || !suspended);
                chk("R10 ctl_in_irq", ctl_in_irq, irq);
            end
        end
    end

    task automatic cyc(); @(negedge clk); endtask

    task automatic idle();
        cmd_valid = 0; bus_reset = 0; status_done = 0;
    endtask

    task automatic send(input bit code, input logic [7:0] b);
        cyc(); idle(); cmd_valid = 1; cmd_is_code = code; cmd_byte = b;
        cyc(); idle();
    endtask

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R12: reset values
        chk("R12 reset addr", dev_addr, 0);
        chk("R12 reset en", dev_en, 1);
        chk("R12 reset cfg", cfg_rd, 0);
        chk("R12 reset mode", mode_rd, 0);

        // R1/R2: address pending until status stage
        send(1, 8'hD0); send(0, 8'h85);
        chk("R2 addr still pending", dev_addr, 0);
        chk("R1 enable from bit7", dev_en, 1);
        cyc(); status_done = 1; cyc(); idle();
        chk("R2 addr active after status", dev_addr, 7'h05);
        cyc(); status_done = 1; cyc(); idle();
        chk("R2 status with nothing pending", dev_addr, 7'h05);

        // R2 collision: write while status_done pulses
        send(1, 8'hD0);
        cyc(); cmd_valid = 1; cmd_is_code = 0; cmd_byte = 8'h99; status_done = 1;
        cyc(); idle();
        chk("R2 same-cycle write stays pending", dev_addr, 7'h05);
        cyc(); status_done = 1; cyc(); idle();
        chk("R2 later commit", dev_addr, 7'h19);

        // R4, R5, R11
        send(1, 8'hD8); send(0, 8'hFF);
        chk("R4 configured", cfg_rd, 8'h01);
        send(0, 8'h00);
        chk("R11 orphan data ignored", cfg_rd, 8'h01);
        send(1, 8'h42); send(0, 8'h00);
        chk("R11 unknown code", cfg_rd, 8'h01);
        send(1, 8'hF3); send(0, 8'hFF);
        chk("R5 mode bits", mode_rd, 8'h03);

        // R3 collision: bus reset wins over config write
        send(1, 8'hD8);
        cyc(); cmd_valid = 1; cmd_is_code = 0; cmd_byte = 8'h01; bus_reset = 1;
        cyc(); idle();
        chk("R3 addr", dev_addr, 0);
        chk("R3 cfg cleared", cfg_rd, 0);
        chk("R3 mode kept", mode_rd, 8'h03);
        send(0, 8'h01);
        chk("R3 decoder idle", cfg_rd, 0);

        // R6-R10 random traffic compared every cycle
        for (int i = 0; i < 4000; i++) begin
            cyc(); idle();
            cmd_valid   = ($urandom % 3) == 0;
            cmd_is_code = $urandom % 2;
            case ($urandom % 5)
                0: cmd_byte = 8'hD0; 1: cmd_byte = 8'hD8; 2: cmd_byte = 8'hF3;
                default: cmd_byte = 8'($urandom);
            endcase
            bus_reset   = ($urandom % 60) == 0;
            status_done = ($urandom % 8) == 0;
            suspended   = ($urandom % 4) == 0;
            tok_valid   = $urandom % 2;
            tok_addr    = ($urandom % 2) ? m_addr[6:0] : 7'($urandom % 4);
            tok_ep      = ($urandom % 2) ? '0 : EP_W'($urandom);
            tok_in      = $urandom % 2;
            ep_en       = NUM_EP'($urandom);
            txn_ok      = $urandom % 2;
            txn_nak     = $urandom % 2;
        end
        cyc(); idle();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule